// File: doc/BRIEF.md
# Sixteen-Source Priority Interrupt Controller

This block gathers interrupt requests from sixteen input lines and presents one interrupt output to a processor. Each line can be set to level or edge sensitivity and can be active high or active low. Requests are held in a pending register. A mask register gates them. An in-service register records requests that have been acknowledged and not yet retired, and a cascade register marks lines that feed from a downstream controller. Software reaches all of this state through a byte-wide register port. A single write to the pending register can set one pending bit, clear one pending bit, or clear a whole byte half.

Two decision modes are available. In fixed-priority mode, a probe starts at a programmable first-priority index and walks upward, wrapping from 15 to 0. The first in-service bit it meets blocks lower requests, except a cascade line that is pending again at its own level. In rotating mode, any in-service bit holds the output low. An acknowledge strobe marks the winning line as in service and returns a byte vector for it. The pending bit of a level line that is still active survives the acknowledge.

Top module: `prio_intc`

## Requirements
- R1: After reset `irq_out` is 0. Mask reads 0xFF in both halves and polarity reads 0xFF in both halves (active high). Trigger mode, pending, in-service, cascade, first index and mode all read 0.
- R2: On a level line (trigger-mode bit 0), the pending bit is set on each clock edge where the line equals its polarity bit, and it is cleared when the line differs. Setting is suppressed while mode bit 1 (freeze) is 1.
- R3: On an edge line (trigger-mode bit 1), the pending bit is set only on the edge where the line changes to its active level. Holding the line active does not set it again after software has cleared it.
- R4: `irq_out` is a register that is updated on each clock edge from the state before that edge. It is 0 whenever no pending bit is unmasked (mask bit 1 means masked).
- R5: In fixed mode (mode bit 0 = 0) with the in-service register at zero, any unmasked pending bit drives `irq_out` to 1.
- R6: In fixed mode with some bit in service, a probe starts at the first index and steps upward, with index 15 followed by 0. If the first hit is an unmasked pending bit that is not in service, `irq_out` is 1. If the first hit is in service, `irq_out` is 1 only when that line is also a cascade line that is pending and unmasked.
- R7: In rotating mode (mode bit 0 = 1), `irq_out` is 1 only when the in-service register is zero and some pending bit is unmasked.
- R8: An `ack_stb` cycle with a winner sets the winner's in-service bit. It clears the winner's pending bit only when the line is edge-triggered or its input is currently at the inactive level. `irq_out` is 0 in the following cycle.
- R9: The acknowledge returns `ack_vec` in the cycle after `ack_stb`. The vector is 0xA0 plus the index of the first unmasked pending line in probe order, or 0xFF when no line qualifies.
- R10: A write to address 6 or 7 (pending command) works as follows. If data bit 6 is 1, the write clears the low half (address 6) or the high half (address 7). Otherwise, if data bit 7 is 1, it sets the pending bit whose index is data bits 3:0. Otherwise it clears that pending bit.
- R11: Register map (low/high byte pairs):
  - 0/1: trigger mode
  - 2/3: polarity
  - 4/5: mask
  - 6/7: pending
  - 8/9: in-service (written directly)
  - 10/11: cascade
  - 12: first index in bits 3:0
  - 14: mode (bit 0 rotating, bit 1 freeze)

  Addresses 13 and 15 read 0. `reg_rdata` shows the addressed register combinationally, and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq_lines | input | 16 | Interrupt request inputs |
| ack_stb | input | 1 | Acknowledge strobe, one cycle |
| ack_vec | output | 8 | Vector returned by the last acknowledge |
| irq_out | output | 1 | Interrupt output to the processor |

## Verification
The hardest state to reach from the ports is a cascade line that is in service and pending again at the same time. For that, the line must be level-triggered and held active through its own acknowledge. Then the cascade flag must be raised while the in-service bit is still set. The directed part of the bench builds this sequence step by step, and it also walks the probe across the 15-to-0 wrap with the first index set to 15. A long random phase then keeps toggling lines, masks, modes and acknowledges, and a cycle model in the bench predicts every output.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

   typedef enum logic [3:0] {
      A_TRIG_L  = 4'd0,
      A_TRIG_H  = 4'd1,
      A_POL_L   = 4'd2,
      A_POL_H   = 4'd3,
      A_MASK_L  = 4'd4,
      A_MASK_H  = 4'd5,
      A_PEND_L  = 4'd6,
      A_PEND_H  = 4'd7,
      A_ISV_L   = 4'd8,
      A_ISV_H   = 4'd9,
      A_CASC_L  = 4'd10,
      A_CASC_H  = 4'd11,
      A_FIRST   = 4'd12,
      A_GAP0    = 4'd13,
      A_MODE    = 4'd14,
      A_GAP1    = 4'd15
   } intc_reg_e;

   // mode register fields
   localparam int MODE_ROT = 0;
   localparam int MODE_FRZ = 1;

   // pending command fields
   localparam int CMD_CLR_HALF = 6;
   localparam int CMD_SET      = 7;

endpackage

// File: rtl/prio_intc_capture.sv
module prio_intc_capture #(
   parameter int NSRC = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] lines,
   input  logic [NSRC-1:0] pol,
   input  logic [NSRC-1:0] edge_sel,
   input  logic            freeze,
   output logic [NSRC-1:0] set_req,
   output logic [NSRC-1:0] clr_req
);

   logic [NSRC-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lines;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_line
      logic act;
      logic chg;
      assign act = (lines[i] == pol[i]);
      assign chg = (lines[i] != prev_q[i]);
      assign set_req[i] = edge_sel[i] ? (act & chg) : (act & ~freeze);
      assign clr_req[i] = ~edge_sel[i] & ~act;
   end

endmodule

// File: rtl/prio_intc_resolve.sv
module prio_intc_resolve #(
   parameter int NSRC  = 16,
   parameter int IDX_W = 4
) (
   input  logic [NSRC-1:0]  pend,
   input  logic [NSRC-1:0]  mask,
   input  logic [NSRC-1:0]  isv,
   input  logic [NSRC-1:0]  casc,
   input  logic [IDX_W-1:0] first,
   input  logic             rot_mode,
   output logic             want_irq,
   output logic             win_found,
   output logic [IDX_W-1:0] win_idx
);

   function automatic logic [NSRC-1:0] rot_dn(input logic [NSRC-1:0] v,
                                              input logic [IDX_W-1:0] s);
      logic [2*NSRC-1:0] d;
      d = {v, v} >> s;
      return d[NSRC-1:0];
   endfunction

   function automatic logic [IDX_W-1:0] low_idx(input logic [NSRC-1:0] v);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int i = NSRC - 1; i >= 0; i--)
         if (v[i]) r = IDX_W'(i);
      return r;
   endfunction

   logic [NSRC-1:0]  upm;
   logic [NSRC-1:0]  r_upm;
   logic [NSRC-1:0]  r_isv;
   logic [NSRC-1:0]  r_casc;
   logic [IDX_W-1:0] hit_p;
   logic [IDX_W-1:0] pend_p;
   logic             fixed_ok;

   assign upm    = pend & ~mask;
   assign r_upm  = rot_dn(upm, first);
   assign r_isv  = rot_dn(isv, first);
   assign r_casc = rot_dn(casc, first);
   assign hit_p  = low_idx(r_upm | r_isv);
   assign pend_p = low_idx(r_upm);

   always_comb begin
      if (isv == '0)        fixed_ok = 1'b1;
      else if (r_isv[hit_p]) fixed_ok = r_casc[hit_p] & r_upm[hit_p];
      else                  fixed_ok = 1'b1;
   end

   assign want_irq  = (|upm) & (rot_mode ? (isv == '0) : fixed_ok);
   assign win_found = |upm;
   assign win_idx   = pend_p + first;

endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
   parameter int          NSRC     = 16,
   parameter int          BYTE_W   = 8,
   parameter int          VEC_W    = 8,
   parameter logic [7:0]  VEC_BASE = 8'hA0,
   parameter logic [7:0]  DEF_VEC  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic [NSRC-1:0]   irq_lines,
   input  logic              ack_stb,
   output logic [VEC_W-1:0]  ack_vec,
   output logic              irq_out
);
   import prio_intc_pkg::*;

   localparam int IDX_W = $clog2(NSRC);

   if (NSRC != 2 * BYTE_W) begin : g_bad_split
      $error("NSRC must equal two register bytes");
   end
   if ((1 << IDX_W) != NSRC) begin : g_bad_pow2
      $error("NSRC must be a power of two");
   end
   if (VEC_W <= IDX_W || VEC_W > 8) begin : g_bad_vec
      $error("VEC_W must exceed the index width and fit the base");
   end

   logic [NSRC-1:0]  trig_q, pol_q, mask_q, pend_q, isv_q, casc_q;
   logic [NSRC-1:0]  pend_n, isv_n;
   logic [IDX_W-1:0] first_q;
   logic             rot_q, frz_q;
   logic             irq_q;
   logic [VEC_W-1:0] vec_q;

   logic [NSRC-1:0]  set_req, clr_req;
   logic             want_irq, win_found;
   logic [IDX_W-1:0] win_idx;
   logic             ack_hit;
   logic [NSRC-1:0]  idle;

   function automatic logic [NSRC-1:0] put_half(input logic [NSRC-1:0]   old,
                                                input logic              hi,
                                                input logic [BYTE_W-1:0] d);
      logic [NSRC-1:0] r;
      r = old;
      if (hi) r[NSRC-1:BYTE_W] = d;
      else    r[BYTE_W-1:0]    = d;
      return r;
   endfunction

   prio_intc_capture #(.NSRC(NSRC)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines    (irq_lines),
      .pol      (pol_q),
      .edge_sel (trig_q),
      .freeze   (frz_q),
      .set_req  (set_req),
      .clr_req  (clr_req)
   );

   prio_intc_resolve #(.NSRC(NSRC), .IDX_W(IDX_W)) u_resolve (
      .pend      (pend_q),
      .mask      (mask_q),
      .isv       (isv_q),
      .casc      (casc_q),
      .first     (first_q),
      .rot_mode  (rot_q),
      .want_irq  (want_irq),
      .win_found (win_found),
      .win_idx   (win_idx)
   );

   assign ack_hit = ack_stb & win_found;
   assign idle    = irq_lines ^ pol_q;

   // pending: software command, then acknowledge, then line capture
   always_comb begin
      pend_n = pend_q;
      if (reg_we && (reg_addr == A_PEND_L || reg_addr == A_PEND_H)) begin
         if (reg_wdata[CMD_CLR_HALF])
            pend_n = put_half(pend_n, reg_addr == A_PEND_H, '0);
         else
            pend_n[reg_wdata[IDX_W-1:0]] = reg_wdata[CMD_SET];
      end
      if (ack_hit && (trig_q[win_idx] || idle[win_idx]))
         pend_n[win_idx] = 1'b0;
      pend_n = (pend_n & ~clr_req) | set_req;
   end

   always_comb begin
      isv_n = isv_q;
      if (reg_we && (reg_addr == A_ISV_L || reg_addr == A_ISV_H))
         isv_n = put_half(isv_n, reg_addr == A_ISV_H, reg_wdata);
      if (ack_hit)
         isv_n[win_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q  <= '0;
         pol_q   <= '1;
         mask_q  <= '1;
         pend_q  <= '0;
         isv_q   <= '0;
         casc_q  <= '0;
         first_q <= '0;
         rot_q   <= 1'b0;
         frz_q   <= 1'b0;
         irq_q   <= 1'b0;
         vec_q   <= DEF_VEC[VEC_W-1:0];
      end else begin
         pend_q <= pend_n;
         isv_q  <= isv_n;
         irq_q  <= ack_stb ? 1'b0 : want_irq;
         if (ack_stb)
            vec_q <= win_found ? {VEC_BASE[VEC_W-1:IDX_W], win_idx} : DEF_VEC[VEC_W-1:0];
         if (reg_we) begin
            case (reg_addr)
               A_TRIG_L: trig_q <= put_half(trig_q, 1'b0, reg_wdata);
               A_TRIG_H: trig_q <= put_half(trig_q, 1'b1, reg_wdata);
               A_POL_L:  pol_q  <= put_half(pol_q, 1'b0, reg_wdata);
               A_POL_H:  pol_q  <= put_half(pol_q, 1'b1, reg_wdata);
               A_MASK_L: mask_q <= put_half(mask_q, 1'b0, reg_wdata);
               A_MASK_H: mask_q <= put_half(mask_q, 1'b1, reg_wdata);
               A_CASC_L: casc_q <= put_half(casc_q, 1'b0, reg_wdata);
               A_CASC_H: casc_q <= put_half(casc_q, 1'b1, reg_wdata);
               A_FIRST:  first_q <= reg_wdata[IDX_W-1:0];
               A_MODE: begin
                  rot_q <= reg_wdata[MODE_ROT];
                  frz_q <= reg_wdata[MODE_FRZ];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_addr)
         A_TRIG_L: reg_rdata = trig_q[BYTE_W-1:0];
         A_TRIG_H: reg_rdata = trig_q[NSRC-1:BYTE_W];
         A_POL_L:  reg_rdata = pol_q[BYTE_W-1:0];
         A_POL_H:  reg_rdata = pol_q[NSRC-1:BYTE_W];
         A_MASK_L: reg_rdata = mask_q[BYTE_W-1:0];
         A_MASK_H: reg_rdata = mask_q[NSRC-1:BYTE_W];
         A_PEND_L: reg_rdata = pend_q[BYTE_W-1:0];
         A_PEND_H: reg_rdata = pend_q[NSRC-1:BYTE_W];
         A_ISV_L:  reg_rdata = isv_q[BYTE_W-1:0];
         A_ISV_H:  reg_rdata = isv_q[NSRC-1:BYTE_W];
         A_CASC_L: reg_rdata = casc_q[BYTE_W-1:0];
         A_CASC_H: reg_rdata = casc_q[NSRC-1:BYTE_W];
         A_FIRST:  reg_rdata = BYTE_W'(first_q);
         A_MODE:   reg_rdata = BYTE_W'({frz_q, rot_q});
         default:  reg_rdata = '0;
      endcase
   end

   assign irq_out = irq_q;
   assign ack_vec = vec_q;

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
   parameter int NSRC  = 16,
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_out,
   input logic             ack_stb,
   input logic             win_found,
   input logic [IDX_W-1:0] win_idx,
   input logic [NSRC-1:0]  pend,
   input logic [NSRC-1:0]  mask,
   input logic [NSRC-1:0]  isv,
   input logic             rot_mode
);

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !irq_out); // R1

   AST_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(|(pend & ~mask))); // R4

   AST_ROT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && $past(rot_mode)) |-> ($past(isv) == '0)); // R7

   AST_ACK_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |=> !irq_out); // R8

   AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && win_found) |=> isv[$past(win_idx)]); // R8

endmodule

bind prio_intc prio_intc_chk #(.NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_out   (irq_out),
   .ack_stb   (ack_stb),
   .win_found (win_found),
   .win_idx   (win_idx),
   .pend      (pend_q),
   .mask      (mask_q),
   .isv       (isv_q),
   .rot_mode  (rot_q)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [15:0] irq_lines = '0;
   logic        ack_stb = 1'b0;
   logic [7:0]  ack_vec;
   logic        irq_out;

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] lines_v = '0;

   // bench model state
   logic [15:0] m_trig, m_pol, m_mask, m_pend, m_isv, m_casc, m_prev;
   logic [3:0]  m_first;
   logic        m_rot, m_frz;

   prio_intc u_prio_intc (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_lines (irq_lines),
      .ack_stb   (ack_stb),
      .ack_vec   (ack_vec),
      .irq_out   (irq_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      summary();
      $finish;
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void m_reset();
      m_trig = '0; m_pol = '1; m_mask = '1; m_pend = '0; m_isv = '0;
      m_casc = '0; m_prev = '0; m_first = '0; m_rot = 1'b0; m_frz = 1'b0;
   endfunction

   function automatic logic m_decide();
      logic [15:0] upm;
      logic [15:0] probe;
      upm = m_pend & ~m_mask;
      if (upm == 0) return 1'b0;
      if (m_rot) return (m_isv == 0);
      if (m_isv == 0) return 1'b1;
      probe = 16'b1 << m_first;
      for (int i = 0; i < 16; i++) begin
         if ((m_isv & probe) != 0) return ((m_casc & upm & probe) != 0);
         if ((upm & probe) != 0) return 1'b1;
         probe = {probe[14:0], probe[15]};
      end
      return 1'b0;
   endfunction

   function automatic logic [4:0] m_winner();
      logic [15:0] upm;
      logic [15:0] probe;
      upm = m_pend & ~m_mask;
      probe = 16'b1 << m_first;
      for (int i = 0; i < 16; i++) begin
         if ((upm & probe) != 0) return {1'b1, 4'(m_first + i)};
         probe = {probe[14:0], probe[15]};
      end
      return 5'b0;
   endfunction

   function automatic logic [7:0] m_read(input logic [3:0] a);
      case (a)
         4'd0:  return m_trig[7:0];
         4'd1:  return m_trig[15:8];
         4'd2:  return m_pol[7:0];
         4'd3:  return m_pol[15:8];
         4'd4:  return m_mask[7:0];
         4'd5:  return m_mask[15:8];
         4'd6:  return m_pend[7:0];
         4'd7:  return m_pend[15:8];
         4'd8:  return m_isv[7:0];
         4'd9:  return m_isv[15:8];
         4'd10: return m_casc[7:0];
         4'd11: return m_casc[15:8];
         4'd12: return {4'b0, m_first};
         4'd14: return {6'b0, m_frz, m_rot};
         default: return 8'h00;
      endcase
   endfunction

   // one clock: inputs are already driven; predict, clock, compare
   task automatic step();
      logic [15:0] upm, np, ni;
      logic        exp_irq, act, we_s, ack_s;
      logic [4:0]  win;
      logic [7:0]  exp_vec, d_s;
      logic [3:0]  a_s;
      logic [15:0] l_s;
      string       tg;
      we_s = reg_we; a_s = reg_addr; d_s = reg_wdata; ack_s = ack_stb; l_s = irq_lines;
      upm = m_pend & ~m_mask;
      exp_irq = ack_s ? 1'b0 : m_decide();
      tg = ack_s ? "R8" : (upm == 0) ? "R4" : m_rot ? "R7" : (m_isv == 0) ? "R5" : "R6";
      win = m_winner();
      exp_vec = win[4] ? {4'hA, win[3:0]} : 8'hFF;
      np = m_pend; ni = m_isv;
      if (we_s && (a_s == 4'd6 || a_s == 4'd7)) begin
         if (d_s[6]) begin
            if (a_s == 4'd7) np[15:8] = 8'h00;
            else             np[7:0]  = 8'h00;
         end else begin
            np[d_s[3:0]] = d_s[7];
         end
      end
      if (we_s && a_s == 4'd8) ni[7:0]  = d_s;
      if (we_s && a_s == 4'd9) ni[15:8] = d_s;
      if (ack_s && win[4]) begin
         ni[win[3:0]] = 1'b1;
         if (m_trig[win[3:0]] || (l_s[win[3:0]] != m_pol[win[3:0]])) np[win[3:0]] = 1'b0;
      end
      for (int i = 0; i < 16; i++) begin
         act = (l_s[i] == m_pol[i]);
         if (m_trig[i]) begin
            if (act && (l_s[i] != m_prev[i])) np[i] = 1'b1;
         end else begin
            if (!act) np[i] = 1'b0;
            else if (!m_frz) np[i] = 1'b1;
         end
      end
      @(posedge clk);
      #1;
      m_pend = np; m_isv = ni; m_prev = l_s;
      if (we_s) begin
         case (a_s)
            4'd0:  m_trig[7:0]  = d_s;
            4'd1:  m_trig[15:8] = d_s;
            4'd2:  m_pol[7:0]   = d_s;
            4'd3:  m_pol[15:8]  = d_s;
            4'd4:  m_mask[7:0]  = d_s;
            4'd5:  m_mask[15:8] = d_s;
            4'd10: m_casc[7:0]  = d_s;
            4'd11: m_casc[15:8] = d_s;
            4'd12: m_first      = d_s[3:0];
            4'd14: begin m_rot = d_s[0]; m_frz = d_s[1]; end
            default: ;
         endcase
      end
      chk({tg, " irq_out"}, 16'(irq_out), 16'(exp_irq));
      if (ack_s) chk("R9 ack_vec", 16'(ack_vec), 16'(exp_vec));
   endtask

   task automatic drive(input logic we, input logic [3:0] a, input logic [7:0] d, input logic ack);
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = d; ack_stb = ack; irq_lines = lines_v;
      #1;
      chk("R11 readback", 16'(reg_rdata), 16'(m_read(a)));
      step();
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      drive(1'b1, a, d, 1'b0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 4'd15, 8'h00, 1'b0);
   endtask

   task automatic ack();
      drive(1'b0, 4'd15, 8'h00, 1'b1);
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = a; ack_stb = 1'b0; irq_lines = lines_v;
      #1;
      chk(tag, 16'(reg_rdata), 16'(exp));
      step();
   endtask

   initial begin
      int unsigned seed;
      seed = 32'h5EED_1234;
      void'($urandom(seed));
      m_reset();
      #2 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq_out", 16'(irq_out), 16'h0);
      rd(4'd0, 8'h00, "R1 trig lo");
      rd(4'd2, 8'hFF, "R1 pol lo");
      rd(4'd3, 8'hFF, "R1 pol hi");
      rd(4'd4, 8'hFF, "R1 mask lo");
      rd(4'd5, 8'hFF, "R1 mask hi");
      rd(4'd6, 8'h00, "R1 pend lo");
      rd(4'd8, 8'h00, "R1 isv lo");
      rd(4'd14, 8'h00, "R1 mode");

      // R2 freeze blocks level capture
      wr(4'd4, 8'h00);
      wr(4'd14, 8'h02);
      lines_v[3] = 1'b1;
      idle(3);
      rd(4'd6, 8'h00, "R2 frozen pend");
      chk("R4 frozen irq", 16'(irq_out), 16'h0);
      wr(4'd14, 8'h00);
      idle(2);
      rd(4'd6, 8'h08, "R2 level pend");
      chk("R5 irq", 16'(irq_out), 16'h1);

      // R3 edge capture
      wr(4'd0, 8'h20);
      lines_v[5] = 1'b1;
      idle(2);
      rd(4'd6, 8'h28, "R3 edge set");
      wr(4'd6, 8'h05);
      idle(3);
      rd(4'd6, 8'h08, "R3 no reset while held");
      lines_v[5] = 1'b0;
      idle(1);
      lines_v[5] = 1'b1;
      idle(2);
      rd(4'd6, 8'h28, "R3 new edge");

      // R8 / R9 acknowledge, level survives
      ack();
      chk("R9 vec line3", 16'(ack_vec), 16'h00A3);
      chk("R8 irq low", 16'(irq_out), 16'h0);
      rd(4'd8, 8'h08, "R8 isv set");
      rd(4'd6, 8'h28, "R8 level kept");
      chk("R6 blocked by isv", 16'(irq_out), 16'h0);
      wr(4'd10, 8'h08);
      idle(2);
      chk("R6 cascade reentry", 16'(irq_out), 16'h1);
      wr(4'd10, 8'h00);
      wr(4'd8, 8'h00);
      wr(4'd4, 8'h08);
      idle(1);
      ack();
      chk("R9 vec line5", 16'(ack_vec), 16'h00A5);
      rd(4'd6, 8'h08, "R8 edge cleared");
      rd(4'd8, 8'h20, "R8 isv line5");

      // R9 / R10 wrap of probe
      lines_v[3] = 1'b0;
      lines_v[5] = 1'b0;
      wr(4'd8, 8'h00);
      wr(4'd4, 8'h00);
      wr(4'd5, 8'h00);
      wr(4'd0, 8'hFF);
      wr(4'd1, 8'hFF);
      idle(2);
      wr(4'd6, 8'h80);
      wr(4'd6, 8'h8E);
      wr(4'd12, 8'h0F);
      rd(4'd6, 8'h01, "R10 set lo");
      rd(4'd7, 8'h40, "R10 set 14 via lo addr");
      ack();
      chk("R9 wrap 15 to 0", 16'(ack_vec), 16'h00A0);
      ack();
      chk("R9 next is 14", 16'(ack_vec), 16'h00AE);
      wr(4'd8, 8'h00);
      wr(4'd9, 8'h00);

      // R6 wrap with in-service
      wr(4'd8, 8'h01);
      wr(4'd7, 8'h8E);
      idle(2);
      chk("R6 isv0 blocks after wrap", 16'(irq_out), 16'h0);
      wr(4'd12, 8'h0D);
      idle(2);
      chk("R6 line14 ahead of isv0", 16'(irq_out), 16'h1);

      // R10 commands
      wr(4'd6, 8'h89);
      wr(4'd7, 8'h8C);
      rd(4'd7, 8'h52, "R10 hi bits");
      wr(4'd7, 8'h40);
      rd(4'd7, 8'h00, "R10 clear hi half");
      wr(4'd7, 8'h82);
      rd(4'd6, 8'h04, "R10 set 2 via hi addr");

      // R7 rotating mode
      wr(4'd14, 8'h01);
      idle(2);
      chk("R7 isv blocks", 16'(irq_out), 16'h0);
      wr(4'd8, 8'h00);
      idle(2);
      chk("R7 isv clear", 16'(irq_out), 16'h1);

      // R9 empty acknowledge
      wr(4'd6, 8'h40);
      idle(1);
      ack();
      chk("R9 default vec", 16'(ack_vec), 16'h00FF);
      wr(4'd14, 8'h00);

      // random phase
      for (int c = 0; c < 4000; c++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[3:0] < 4'd3) lines_v[r[7:4]] = ~lines_v[r[7:4]];
         if (r[11:8] < 4'd5)
            drive(1'b1, 4'($urandom % 16), 8'($urandom), 1'b0);
         else
            drive(1'b0, 4'($urandom % 16), 8'h00, (r[15:12] < 4'd2));
      end

      summary();
      $finish;
   end

endmodule